// File: doc/BRIEF.md
# Configurable Macrocell Register

A single logic cell output stage. It takes the sum-of-products result of the product-term logic, passes it through a programmable inverter (an XOR with a configuration bit) and hands it to one storage element. That element can be set up as an edge-triggered D register, a transparent flow-through D latch or a T flip-flop. Static configuration inputs pick where its clock, clock enable, reset and preset come from, and which level of each of those signals counts as active.

The cell runs inside a synchronous fabric. The chosen "clock" source is a level signal that is sampled on the system clock `clk`. An active edge is the first system-clock cycle in which the selected, polarity-corrected level is high while it was low in the cycle before. The source clock is never gated: enables only qualify the update. Reset and preset override the stored value at once, on the outputs in the same cycle, and they also load the storage element at the next system-clock edge. The cell has two outputs, one for local feedback and one for the interconnect. Each output has its own select bit, so one output can carry the stored value while the other carries the combinational result.

Top module: `macrocell_reg`

## Requirements
- R1: After `rst_n` is released, the stored value is 0, so any output that selects the stored value reads 0.
- R2: The combinational result is `sop_in XOR cfg_xor_inv`.
- R3: When `cfg_mode` is 0 or 3 (D register), the stored value loads the combinational result at the system-clock edge that ends the first cycle in which the selected clock level is active after an inactive cycle. The enable must be active in that cycle. The stored value holds otherwise.
- R4: When `cfg_mode` is 1 (latch), an output that selects the stored value follows the combinational result in the same cycle while the selected clock level and the enable are both active. The latch keeps the last value it passed while either of them is inactive.
- R5: When `cfg_mode` is 2 (toggle), an enabled active clock edge inverts the stored value if the combinational result is 1, and leaves it unchanged if the result is 0.
- R6: `cfg_clk_sel` chooses the clock level: 0 = `gclk[cfg_gclk_idx]`, 1 = `lclk`, 2 = `pt_clk`, 3 = `pt_clk_shared`.
- R7: `cfg_en_sel` chooses the enable: 0 = always enabled, 1 = `gen`, 2 = `len`, 3 = `pt_en`. An inactive enable blocks every update of the storage element.
- R8: `cfg_rst_sel` and `cfg_pst_sel` each choose 0 = off, 1 = global (`grst` or `gpst`), 2 = product term (`pt_rst` or `pt_pst`), 3 = off. An active reset forces the stored-value path to 0 and an active preset forces it to 1, in the same cycle, and the forced value stays after they are released.
- R9: When reset and preset are active together, reset wins and the value is 0.
- R10: `cfg_pol` sets the active level per control signal: bit 0 clock, bit 1 enable, bit 2 reset, bit 3 preset. A bit of 1 means the signal is active low.
- R11: `cfg_fb_comb` and `cfg_ic_comb` each pick, for `fb_out` and `ic_out` in turn, the combinational result (1) or the stored value (0), independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sop_in | input | 1 | Sum-of-products input |
| cfg_xor_inv | input | 1 | XOR operand: 1 inverts the data |
| cfg_mode | input | 2 | Storage mode: 0/3 D register, 1 latch, 2 toggle |
| cfg_clk_sel | input | 2 | Clock source select |
| cfg_gclk_idx | input | GIDX_W | Global clock index |
| cfg_en_sel | input | 2 | Clock enable source select |
| cfg_rst_sel | input | 2 | Reset source select |
| cfg_pst_sel | input | 2 | Preset source select |
| cfg_pol | input | 4 | Active-low flags: clock, enable, reset, preset |
| cfg_fb_comb | input | 1 | Feedback output carries the combinational result |
| cfg_ic_comb | input | 1 | Interconnect output carries the combinational result |
| gclk | input | NUM_GCLK | Global clock levels |
| lclk | input | 1 | Local clock level |
| pt_clk | input | 1 | Per-cell product-term clock |
| pt_clk_shared | input | 1 | Shared product-term clock |
| gen | input | 1 | Global clock enable |
| len | input | 1 | Local clock enable |
| pt_en | input | 1 | Product-term clock enable |
| grst | input | 1 | Global reset |
| pt_rst | input | 1 | Product-term reset |
| gpst | input | 1 | Global preset |
| pt_pst | input | 1 | Product-term preset |
| fb_out | output | 1 | Feedback output |
| ic_out | output | 1 | Interconnect output |

## Verification
On every cycle the assertions check these rules: reset beats preset and clears the state, a detected clock edge lasts a single cycle, the D register holds when it sees no qualified edge, a qualified toggle with data 1 flips the state, and an output with its combinational select set carries the XOR result. Only the bench's scenarios can show behaviour that depends on which source the configuration picks and on its polarity. These are the latch's flow-through and hold, a blocked enable, a source switch without a false edge, and the same-cycle forcing by reset and preset. The bench shows them with a behavioural model that it compares on every cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    ST_DREG     = 2'd0,
    ST_LATCH    = 2'd1,
    ST_TOGGLE   = 2'd2,
    ST_DREG_ALT = 2'd3
  } store_mode_e;

  // Polarity correction: a set low_active flag turns a low level into "active".
  function automatic logic act_level(input logic raw, input logic low_active);
    return raw ^ low_active;
  endfunction

  // Programmable inverter in front of the storage element.
  function automatic logic xor_gate(input logic sop, input logic inv);
    return sop ^ inv;
  endfunction

  // Storage update when no reset or preset is active.
  function automatic logic store_next(input store_mode_e mode, input logic q,
                                      input logic d, input logic edge_en,
                                      input logic level_en);
    logic n;
    n = q;
    case (mode)
      ST_LATCH:  if (level_en) n = d;
      ST_TOGGLE: if (edge_en && d) n = ~q;
      default:   if (edge_en) n = d;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mc_ctrl_sel.sv
module mc_ctrl_sel #(
  parameter int NUM_GCLK = 4,
  parameter int GIDX_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [GIDX_W-1:0]   gclk_idx,
  input  logic                lclk,
  input  logic                pt_clk,
  input  logic                pt_clk_shared,
  input  logic [1:0]          clk_sel,
  input  logic                gen,
  input  logic                len,
  input  logic                pt_en,
  input  logic [1:0]          en_sel,
  input  logic                grst,
  input  logic                pt_rst,
  input  logic [1:0]          rst_sel,
  input  logic                gpst,
  input  logic                pt_pst,
  input  logic [1:0]          pst_sel,
  input  logic [3:0]          pol,
  output logic                clk_lvl,
  output logic                clk_edge,
  output logic                en_act,
  output logic                rst_act,
  output logic                pst_act
);
  import mc_pkg::*;

  logic gclk_pick;
  logic clk_raw;
  logic lvl_prev;

  generate
    if (NUM_GCLK > 1) begin : g_multi
      always_comb begin
        gclk_pick = 1'b0;
        for (int i = 0; i < NUM_GCLK; i++)
          if (gclk_idx == GIDX_W'(i)) gclk_pick = gclk[i];
      end
    end else begin : g_single
      assign gclk_pick = gclk[0];
    end
  endgenerate

  always_comb begin
    case (clk_sel)
      2'd0:    clk_raw = gclk_pick;
      2'd1:    clk_raw = lclk;
      2'd2:    clk_raw = pt_clk;
      default: clk_raw = pt_clk_shared;
    endcase
  end

  assign clk_lvl = act_level(clk_raw, pol[0]);

  always_comb begin
    case (en_sel)
      2'd0:    en_act = 1'b1;
      2'd1:    en_act = act_level(gen, pol[1]);
      2'd2:    en_act = act_level(len, pol[1]);
      default: en_act = act_level(pt_en, pol[1]);
    endcase
  end

  always_comb begin
    case (rst_sel)
      2'd1:    rst_act = act_level(grst, pol[2]);
      2'd2:    rst_act = act_level(pt_rst, pol[2]);
      default: rst_act = 1'b0;
    endcase
    case (pst_sel)
      2'd1:    pst_act = act_level(gpst, pol[3]);
      2'd2:    pst_act = act_level(pt_pst, pol[3]);
      default: pst_act = 1'b0;
    endcase
  end

  // Previous level starts at 1 so a level already high at release is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b1;
    else        lvl_prev <= clk_lvl;
  end

  assign clk_edge = clk_lvl & ~lvl_prev;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_edge |=> !clk_edge); // R3

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       d,
  input  logic       clk_lvl,
  input  logic       clk_edge,
  input  logic       en_act,
  input  logic       rst_act,
  input  logic       pst_act,
  output logic       q_vis
);
  import mc_pkg::*;

  store_mode_e mode_e;
  logic        q_state;
  logic        edge_en;
  logic        level_en;
  logic        flow;

  assign mode_e   = store_mode_e'(mode);
  assign edge_en  = clk_edge & en_act;
  assign level_en = clk_lvl & en_act;
  assign flow     = (mode_e == ST_LATCH) & level_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_state <= 1'b0;
    else if (rst_act) q_state <= 1'b0;
    else if (pst_act) q_state <= 1'b1;
    else              q_state <= store_next(mode_e, q_state, d, edge_en, level_en);
  end

  always_comb begin
    if (rst_act)      q_vis = 1'b0;
    else if (pst_act) q_vis = 1'b1;
    else if (flow)    q_vis = d;
    else              q_vis = q_state;
  end

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> !q_state); // R8
  AST_RST_OVER_PST: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && pst_act) |=> (q_state == 1'b0)); // R9
  AST_DREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_e == ST_DREG || mode_e == ST_DREG_ALT) && !rst_act && !pst_act && !edge_en)
      |=> $stable(q_state)); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == ST_TOGGLE && !rst_act && !pst_act && edge_en && d)
      |=> (q_state != $past(q_state))); // R5

endmodule

// File: rtl/mc_out_sel.sv
module mc_out_sel #(
  parameter int NUM_OUT = 2
) (
  input  logic               comb_val,
  input  logic               reg_val,
  input  logic [NUM_OUT-1:0] use_comb,
  output logic [NUM_OUT-1:0] outs
);
  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign outs[i] = use_comb[i] ? comb_val : reg_val;
    end
  endgenerate
endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg #(
  parameter int NUM_GCLK = 4,
  parameter int GIDX_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sop_in,
  input  logic                cfg_xor_inv,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_clk_sel,
  input  logic [GIDX_W-1:0]   cfg_gclk_idx,
  input  logic [1:0]          cfg_en_sel,
  input  logic [1:0]          cfg_rst_sel,
  input  logic [1:0]          cfg_pst_sel,
  input  logic [3:0]          cfg_pol,
  input  logic                cfg_fb_comb,
  input  logic                cfg_ic_comb,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                lclk,
  input  logic                pt_clk,
  input  logic                pt_clk_shared,
  input  logic                gen,
  input  logic                len,
  input  logic                pt_en,
  input  logic                grst,
  input  logic                pt_rst,
  input  logic                gpst,
  input  logic                pt_pst,
  output logic                fb_out,
  output logic                ic_out
);
  import mc_pkg::*;

  localparam int NUM_OUT = 2;

  logic               d_comb;
  logic               clk_lvl;
  logic               clk_edge;
  logic               en_act;
  logic               rst_act;
  logic               pst_act;
  logic               q_vis;
  logic [NUM_OUT-1:0] outs;

  assign d_comb = xor_gate(sop_in, cfg_xor_inv);

  mc_ctrl_sel #(.NUM_GCLK(NUM_GCLK), .GIDX_W(GIDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gclk(gclk), .gclk_idx(cfg_gclk_idx),
    .lclk(lclk), .pt_clk(pt_clk), .pt_clk_shared(pt_clk_shared),
    .clk_sel(cfg_clk_sel), .gen(gen), .len(len), .pt_en(pt_en),
    .en_sel(cfg_en_sel), .grst(grst), .pt_rst(pt_rst), .rst_sel(cfg_rst_sel),
    .gpst(gpst), .pt_pst(pt_pst), .pst_sel(cfg_pst_sel), .pol(cfg_pol),
    .clk_lvl(clk_lvl), .clk_edge(clk_edge), .en_act(en_act),
    .rst_act(rst_act), .pst_act(pst_act)
  );

  mc_store u_store (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .d(d_comb),
    .clk_lvl(clk_lvl), .clk_edge(clk_edge), .en_act(en_act),
    .rst_act(rst_act), .pst_act(pst_act), .q_vis(q_vis)
  );

  mc_out_sel #(.NUM_OUT(NUM_OUT)) u_out (
    .comb_val(d_comb), .reg_val(q_vis),
    .use_comb({cfg_ic_comb, cfg_fb_comb}), .outs(outs)
  );

  assign fb_out = outs[0];
  assign ic_out = outs[1];

  AST_FB_COMB: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fb_comb |-> (fb_out == (sop_in ^ cfg_xor_inv))); // R11
  AST_IC_COMB: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ic_comb |-> (ic_out == (sop_in ^ cfg_xor_inv))); // R2

endmodule

// File: tb/tb_macrocell_reg.sv
module tb_macrocell_reg;
  localparam int NG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop_in = 0, cfg_xor_inv = 0, cfg_fb_comb = 0, cfg_ic_comb = 0;
  logic [1:0] cfg_mode = 0, cfg_clk_sel = 0, cfg_en_sel = 0, cfg_rst_sel = 0, cfg_pst_sel = 0;
  logic [1:0] cfg_gclk_idx = 0;
  logic [3:0] cfg_pol = 0;
  logic [NG-1:0] gclk = 0;
  logic lclk = 0, pt_clk = 0, pt_clk_shared = 0, gen = 0, len = 0, pt_en = 0;
  logic grst = 0, pt_rst = 0, gpst = 0, pt_pst = 0;
  logic fb_out, ic_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mq = 0;
  int mprev = 1;

  always #10 clk = ~clk;

  macrocell_reg #(.NUM_GCLK(NG)) dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int m_lvl();
    int r;
    if (cfg_clk_sel == 0)      r = gclk[cfg_gclk_idx];
    else if (cfg_clk_sel == 1) r = lclk;
    else if (cfg_clk_sel == 2) r = pt_clk;
    else                       r = pt_clk_shared;
    return (cfg_pol[0]) ? 1 - r : r;
  endfunction

  function automatic int m_en();
    int r;
    if (cfg_en_sel == 0) return 1;
    r = (cfg_en_sel == 1) ? gen : (cfg_en_sel == 2) ? len : pt_en;
    return (cfg_pol[1]) ? 1 - r : r;
  endfunction

  function automatic int m_ctl(input int sel, input int g, input int p, input int lo);
    int r;
    if (sel != 1 && sel != 2) return 0;
    r = (sel == 1) ? g : p;
    return lo ? 1 - r : r;
  endfunction

  function automatic int m_d();
    return (sop_in != cfg_xor_inv) ? 1 : 0;
  endfunction

  function automatic int m_vis();
    if (m_ctl(cfg_rst_sel, grst, pt_rst, cfg_pol[2]) == 1) return 0;
    if (m_ctl(cfg_pst_sel, gpst, pt_pst, cfg_pol[3]) == 1) return 1;
    if (cfg_mode == 1 && m_lvl() == 1 && m_en() == 1) return m_d();
    return mq;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Compare both outputs with the model, then advance one system clock.
  task automatic step(input string tag);
    int l, e, rs, ps, d;
    #1;
    chk(tag, fb_out, cfg_fb_comb ? m_d() : m_vis());
    chk(tag, ic_out, cfg_ic_comb ? m_d() : m_vis());
    l = m_lvl(); e = m_en(); d = m_d();
    rs = m_ctl(cfg_rst_sel, grst, pt_rst, cfg_pol[2]);
    ps = m_ctl(cfg_pst_sel, gpst, pt_pst, cfg_pol[3]);
    @(posedge clk);
    if (rs == 1) mq = 0;
    else if (ps == 1) mq = 1;
    else if (cfg_mode == 1) begin
      if (l == 1 && e == 1) mq = d;
    end else if (cfg_mode == 2) begin
      if (l == 1 && mprev == 0 && e == 1 && d == 1) mq = 1 - mq;
    end else if (l == 1 && mprev == 0 && e == 1) mq = d;
    mprev = l;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1", fb_out, 0); chk("R1", ic_out, 0);
    step("R1");

    // R2 / R11: feedback combinational, interconnect registered
    cfg_fb_comb = 1; sop_in = 1; cfg_xor_inv = 1;
    #1 chk("R2", fb_out, 0);
    cfg_xor_inv = 0;
    #1 chk("R2", fb_out, 1); chk("R11", ic_out, 0);
    step("R2");
    cfg_fb_comb = 0;

    // R3 / R6: D register on global clock 2
    cfg_gclk_idx = 2; sop_in = 1; step("R3");
    gclk = 4'b0100; step("R3");
    #1 chk("R3", ic_out, 1);
    sop_in = 0; step("R3");
    #1 chk("R3", ic_out, 1);

    // R6: switch to the shared product-term clock without a false edge
    cfg_clk_sel = 3; pt_clk_shared = 0; step("R6");
    pt_clk_shared = 1; step("R6");
    #1 chk("R6", ic_out, 0);

    // R5: toggle on local clock
    cfg_mode = 2; cfg_clk_sel = 1; lclk = 0; sop_in = 1; step("R5");
    lclk = 1; step("R5");
    #1 chk("R5", ic_out, 1);
    lclk = 0; step("R5"); lclk = 1; step("R5");
    #1 chk("R5", ic_out, 0);
    sop_in = 0; lclk = 0; step("R5"); lclk = 1; step("R5");
    #1 chk("R5", ic_out, 0);

    // R4: latch on per-cell product-term clock
    cfg_mode = 1; cfg_clk_sel = 2; pt_clk = 1; sop_in = 1;
    #1 chk("R4", ic_out, 1);
    sop_in = 0;
    #1 chk("R4", ic_out, 0);
    step("R4");
    pt_clk = 0; sop_in = 1;
    #1 chk("R4", ic_out, 0);
    step("R4");

    // R7: local enable blocks the update
    cfg_mode = 0; cfg_clk_sel = 1; lclk = 0; cfg_en_sel = 2; len = 0; sop_in = 1; step("R7");
    lclk = 1; step("R7");
    #1 chk("R7", ic_out, 0);
    len = 1; lclk = 0; step("R7"); lclk = 1; step("R7");
    #1 chk("R7", ic_out, 1);
    cfg_en_sel = 0;

    // R8 / R9: reset and preset
    cfg_rst_sel = 2; pt_rst = 1;
    #1 chk("R8", ic_out, 0);
    step("R8");
    pt_rst = 0;
    #1 chk("R8", ic_out, 0);
    cfg_pst_sel = 1; gpst = 1;
    #1 chk("R8", ic_out, 1);
    pt_rst = 1;
    #1 chk("R9", ic_out, 0);
    step("R9");
    pt_rst = 0; gpst = 0; cfg_pst_sel = 0; cfg_rst_sel = 0;

    // R10: active-low reset and preset
    cfg_rst_sel = 1; cfg_pol = 4'b0100; grst = 0;
    #1 chk("R10", ic_out, 0);
    grst = 1; cfg_pst_sel = 1; cfg_pol = 4'b1100; gpst = 0;
    #1 chk("R10", ic_out, 1);
    step("R10");
    cfg_rst_sel = 0; cfg_pst_sel = 0; cfg_pol = 0;

    // R11: outputs carry different functions at once
    sop_in = 0; cfg_fb_comb = 1; cfg_ic_comb = 0;
    #1 chk("R11", fb_out, 0); chk("R11", ic_out, 1);
    step("R11");

    // Random configurations and stimulus, model compared every cycle (R10, R6)
    for (int n = 0; n < 3000; n++) begin
      if (n % 24 == 0) begin
        cfg_mode = 2'($urandom); cfg_clk_sel = 2'($urandom); cfg_gclk_idx = 2'($urandom);
        cfg_en_sel = 2'($urandom); cfg_rst_sel = 2'($urandom); cfg_pst_sel = 2'($urandom);
        cfg_pol = 4'($urandom); cfg_xor_inv = 1'($urandom);
        cfg_fb_comb = 1'($urandom); cfg_ic_comb = 1'($urandom);
      end
      sop_in = 1'($urandom); gclk = 4'($urandom); lclk = 1'($urandom);
      pt_clk = 1'($urandom); pt_clk_shared = 1'($urandom);
      gen = 1'($urandom); len = 1'($urandom); pt_en = 1'($urandom);
      grst = ($urandom % 8 == 0); pt_rst = ($urandom % 8 == 0);
      gpst = ($urandom % 6 == 0); pt_pst = ($urandom % 6 == 0);
      if (cfg_pol[2]) begin grst = ~grst; pt_rst = ~pt_rst; end
      if (cfg_pol[3]) begin gpst = ~gpst; pt_pst = ~pt_pst; end
      step("R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule